// File: doc/BRIEF.md
# Register bank with atomic set, clear and toggle aliases

This block holds a bank of memory-mapped control registers behind a simple single-cycle bus. The bus carries an address, a write strobe, a read strobe, write data and read data. Every register takes a 16-byte address window. A write at the first word of the window replaces the register. When aliases are enabled for that register, the other three words let software set, clear or invert chosen bits with one write. No read-modify-write sequence is needed, and a hardware agent that changes other bits of the same register in the meantime cannot be overwritten.

The bank has two parts. The first is a run of individually configured registers. Each one has its own reset value and its own access direction: read-write, read-only or write-only. Each one can also have its aliases turned off. The second part is a strided array of identical registers that starts at a configurable base address. Every register value is driven out to the surrounding peripheral logic. An illegal access changes nothing and raises a one-cycle error pulse.

Top module: `sct_reg_bank`

## Requirements
- R1: While rst_ni is low, every register takes its parameterised reset value. After reset, err_o is low.
- R2: A write at window offset 0x0 loads wdata_i into the register at the next rising clock edge. A read in the following cycle returns the new value.
- R3: A write at window offset 0x4 ORs wdata_i into the register. Bits written as 0 keep their value.
- R4: A write at window offset 0x8 clears every bit that is 1 in wdata_i. The new value is the old value AND NOT wdata_i.
- R5: A write at window offset 0xC XORs wdata_i into the register.
- R6: On a register with aliases, a read at offset 0x4, 0x8 or 0xC returns the register value, just as a read at offset 0x0 does.
- R7: On a register with aliases disabled, offsets 0x4, 0x8 and 0xC are unmapped. A write there changes nothing, and any access there raises an error.
- R8: A write to a read-only register leaves it unchanged and raises an error. Reads of it return its value without an error.
- R9: A read of a write-only register returns 0 and raises an error. Writes to it update the value on regs_o.
- R10: An access to an unmapped address changes no register, raises an error and reads as 0. Unmapped addresses include those with addr_i[1:0] not equal to 0, holes in the address space, and the unused part of each array stride.
- R11: Array element i decodes at ARR_BASE + i*ARR_STRIDE. Each element has its own storage and all four window functions. At most one register decodes for any address.
- R12: err_o is high for exactly one cycle: the cycle after an illegal access. It is low after every legal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data or bit mask |
| rdata_o | output | DATA_W | Read data, valid in the cycle of rd_i |
| err_o | output | 1 | One-cycle error pulse, registered |
| regs_o | output | NREG*DATA_W | All register values; register k sits at [k*DATA_W +: DATA_W] |

## Verification
The bench builds the block with its default parameters and an 8-bit address space. That configuration has four single registers: one read-write, one with aliases disabled, one read-only and one write-only. It also has three array elements with a 32-byte stride starting at 0x80. Each of the 256 byte addresses is written twice, with two different data patterns, and read back after each write pass. This covers every window offset of every register kind, the unmapped middle region, the upper half of each array stride, and every misaligned address. Expected values come from a reference model that decodes the address arithmetically.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } op_e;

  localparam int unsigned WIN_BYTES = 16;
  localparam int unsigned WIN_LSB   = 4;
endpackage

// File: rtl/sct_addr_decode.sv
module sct_addr_decode
  import sct_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_SINGLE  = 4,
  parameter int unsigned ARR_LEN     = 3,
  parameter int unsigned ARR_BASE    = 128,
  parameter int unsigned ARR_STRIDE  = 32,
  parameter logic [NUM_SINGLE-1:0] REG_RO      = '0,
  parameter logic [NUM_SINGLE-1:0] REG_WO      = '0,
  parameter logic [NUM_SINGLE-1:0] REG_NOALIAS = '0,
  parameter bit ARR_RO      = 1'b0,
  parameter bit ARR_WO      = 1'b0,
  parameter bit ARR_NOALIAS = 1'b0,
  localparam int unsigned NREG = NUM_SINGLE + ARR_LEN
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   hit_o,
  output op_e               op_o,
  output logic              hit_ro_o,
  output logic              hit_wo_o
);
  logic [NREG-1:0] ro_v, wo_v;
  logic            aligned, base_word;

  assign aligned   = (addr_i[1:0] == 2'b00);
  assign base_word = (addr_i[3:2] == 2'b00);

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    if (k < NUM_SINGLE) begin : g_single
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(k * WIN_BYTES);
      localparam bit NA = REG_NOALIAS[k];
      assign hit_o[k] = aligned && (addr_i[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB])
                        && (!NA || base_word);
      assign ro_v[k]  = REG_RO[k];
      assign wo_v[k]  = REG_WO[k];
    end else begin : g_array
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ARR_BASE + (k - NUM_SINGLE) * ARR_STRIDE);
      assign hit_o[k] = aligned && (addr_i[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB])
                        && (!ARR_NOALIAS || base_word);
      assign ro_v[k]  = ARR_RO;
      assign wo_v[k]  = ARR_WO;
    end
  end

  assign op_o     = op_e'(addr_i[3:2]);
  assign hit_ro_o = |(hit_o & ro_v);
  assign hit_wo_o = |(hit_o & wo_v);
endmodule

// File: rtl/sct_reg_cell.sv
module sct_reg_cell
  import sct_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] RST_VAL   = '0,
  parameter bit                READ_ONLY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (op_i)
      OP_SET:  nxt = q_o | wdata_i;
      OP_CLR:  nxt = q_o & ~wdata_i;
      OP_TOG:  nxt = q_o ^ wdata_i;
      default: nxt = wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= nxt;
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_SET |=>
      ((q_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_CLR |=> (q_o & $past(wdata_i)) == '0);

  p_tog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_TOG |=> (q_o ^ $past(q_o)) == $past(wdata_i));

  if (READ_ONLY) begin : g_ro_chk
    p_ro_const_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o == RST_VAL);
  end
endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
  import sct_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_SINGLE = 4,
  parameter int unsigned ARR_LEN    = 3,
  parameter int unsigned ARR_BASE   = 128,
  parameter int unsigned ARR_STRIDE = 32,
  parameter logic [NUM_SINGLE-1:0] REG_RO      = 4'b0100,
  parameter logic [NUM_SINGLE-1:0] REG_WO      = 4'b1000,
  parameter logic [NUM_SINGLE-1:0] REG_NOALIAS = 4'b0010,
  parameter logic [NUM_SINGLE*DATA_W-1:0] REG_RST =
    {32'h0000_00F0, 32'hA5A5_5A5A, 32'h1234_5678, 32'hDEAD_BEEF},
  parameter bit                ARR_RO      = 1'b0,
  parameter bit                ARR_WO      = 1'b0,
  parameter bit                ARR_NOALIAS = 1'b0,
  parameter logic [DATA_W-1:0] ARR_RST     = 32'h0000_0001,
  localparam int unsigned NREG = NUM_SINGLE + ARR_LEN
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   err_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [NREG-1:0]   hit;
  op_e               op;
  logic              hit_ro, hit_wo, mapped;
  logic              wr_bad, rd_bad;
  logic [DATA_W-1:0] rd_val;

  sct_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_SINGLE(NUM_SINGLE), .ARR_LEN(ARR_LEN),
    .ARR_BASE(ARR_BASE), .ARR_STRIDE(ARR_STRIDE),
    .REG_RO(REG_RO), .REG_WO(REG_WO), .REG_NOALIAS(REG_NOALIAS),
    .ARR_RO(ARR_RO), .ARR_WO(ARR_WO), .ARR_NOALIAS(ARR_NOALIAS)
  ) u_dec (
    .addr_i  (addr_i),
    .hit_o   (hit),
    .op_o    (op),
    .hit_ro_o(hit_ro),
    .hit_wo_o(hit_wo)
  );

  assign mapped = |hit;
  assign wr_bad = wr_i && (!mapped || hit_ro);
  assign rd_bad = rd_i && (!mapped || hit_wo);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic we;
    assign we = wr_i && hit[k] && !hit_ro;
    if (k < NUM_SINGLE) begin : g_single
      sct_reg_cell #(
        .DATA_W(DATA_W), .RST_VAL(REG_RST[k*DATA_W +: DATA_W]), .READ_ONLY(REG_RO[k])
      ) u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .op_i(op),
        .wdata_i(wdata_i), .q_o(regs_o[k*DATA_W +: DATA_W])
      );
    end else begin : g_array
      sct_reg_cell #(
        .DATA_W(DATA_W), .RST_VAL(ARR_RST), .READ_ONLY(ARR_RO)
      ) u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .op_i(op),
        .wdata_i(wdata_i), .q_o(regs_o[k*DATA_W +: DATA_W])
      );
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NREG; k++) begin
      if (hit[k]) rd_val = regs_o[k*DATA_W +: DATA_W];
    end
  end

  assign rdata_o = (rd_i && !rd_bad) ? rd_val : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= wr_bad || rd_bad;
  end

  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  p_err_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i || rd_i));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) && !mapped |=> err_o);

  p_wo_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && hit_wo |-> rdata_o == '0);

  p_ro_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && hit_ro |=> err_o && $stable(regs_o));
endmodule

// File: tb/sct_reg_bank_bench.sv
module sct_reg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [NR*32-1:0] regs;

  int n_chk = 0, n_err = 0;
  logic [31:0] mdl [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  sct_reg_bank u_sct_reg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // index of decoded register, -1 when unmapped
  function automatic int ref_idx(input logic [7:0] a);
    int off;
    if (a[1:0] != 2'b00) return -1;
    if (a < 8'h40) begin
      if (a[5:4] == 2'd1 && a[3:2] != 2'b00) return -1;
      return int'(a[5:4]);
    end
    if (a >= 8'h80) begin
      off = int'(a) - 128;
      if ((off % 32) < 16 && (off / 32) < 3) return 4 + off / 32;
    end
    return -1;
  endfunction

  function automatic string bad_tag(input logic [7:0] a);
    if (a < 8'h40 && a[1:0] == 2'b00 && a[5:4] == 2'd1) return "R7";
    return "R10";
  endfunction

  task automatic chk_all(input string tag);
    for (int r = 0; r < NR; r++) chk(tag, regs[r*32 +: 32], mdl[r]);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    int    idx;
    bit    bad;
    string tag;
    idx = ref_idx(a);
    bad = (idx < 0) || (idx == 2);
    if (idx < 0)       tag = bad_tag(a);
    else if (idx == 2) tag = "R8";
    else if (idx >= 4) tag = "R11";
    else case (a[3:2])
      2'd1:    tag = "R3";
      2'd2:    tag = "R4";
      2'd3:    tag = "R5";
      default: tag = (idx == 3) ? "R9" : "R2";
    endcase
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
    if (!bad) begin
      case (a[3:2])
        2'd1:    mdl[idx] = mdl[idx] | d;
        2'd2:    mdl[idx] = mdl[idx] & ~d;
        2'd3:    mdl[idx] = mdl[idx] ^ d;
        default: mdl[idx] = d;
      endcase
    end
    chk(tag, {31'd0, err}, {31'd0, bad});
    chk_all(tag);
  endtask

  task automatic do_read(input logic [7:0] a);
    int          idx;
    bit          bad;
    string       tag;
    logic [31:0] cap;
    idx = ref_idx(a);
    bad = (idx < 0) || (idx == 3);
    if (idx < 0)             tag = bad_tag(a);
    else if (idx == 3)       tag = "R9";
    else if (a[3:2] != 2'd0) tag = "R6";
    else                     tag = "R2";
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 cap = rdata;
    @(posedge clk);
    #1 rd = 1'b0;
    chk(tag, cap, bad ? 32'd0 : mdl[idx]);
    chk(tag, {31'd0, err}, {31'd0, bad});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    mdl[0] = 32'hDEAD_BEEF; mdl[1] = 32'h1234_5678; mdl[2] = 32'hA5A5_5A5A;
    mdl[3] = 32'h0000_00F0; mdl[4] = 32'h1; mdl[5] = 32'h1; mdl[6] = 32'h1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk_all("R1");
    chk("R1", {31'd0, err}, 32'd0);

    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 256; a++) begin
        logic [7:0] b;
        b = 8'(a);
        if (p == 0) do_write(b, {b, ~b, b ^ 8'h3C, 8'h96});
        else        do_write(b, {8'hF0 ^ b, b, 8'h0F, ~b});
      end
      for (int a = 0; a < 256; a++) do_read(8'(a));
    end

    // one-cycle error pulse on an unmapped write into an array gap
    do_write(8'h90, 32'hFFFF_FFFF);
    @(posedge clk);
    #1 chk("R12", {31'd0, err}, 32'd0);
    do_write(8'h0C, 32'h0000_FFFF);
    chk("R12", {31'd0, err}, 32'd0);
    do_read(8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule